// File: doc/BRIEF.md
# Debug Execution Control Port

This block gives a host controller indirect access to a small embedded core. Through a 32-bit register bus the host can load and inspect the core's instruction memory, data memory and a bank of context registers. It can also start, stop and single-step the core, flush its pipeline, and read back its run state and counters. The memories are never mapped onto the bus. Every access goes through an address register and a data register, and is triggered by writing an opcode to the control register.

The core is a stub. Each executed instruction advances the program counter by one word, wrapping at the end of instruction memory. An execution counter counts executed instructions. A profile counter counts cycles spent in the free-running state. Host writes take effect on the clock edge where `host_we` is high. Reads are combinational from `host_addr`.

Top module: `dbg_exec_port`

## Requirements
- R1: After reset the core is stopped and the program counter is zero. The control register reads 0x4080_0000: bit 30 (stopped) and bit 23 (pipeline clean) are set. The execution count, profile count, address register and data register all read zero.
- R2: Registers are decoded by byte offset: 0x00 is the access address, 0x04 the access data, 0x08 control/status, 0x0C the execution count and 0x28 the profile count. The address and data registers read back what was written. Every other offset reads zero.
- R3: Opcode 0x11 writes the data register into instruction memory, and 0x13 writes it into data memory, both at the word address in the address register taken modulo the memory depth. Opcodes 0x10 and 0x12 read those memories. The result is in the data register one cycle after the command write, and busy (status bit 28) is high for exactly that one cycle.
- R4: Opcode 0x15 writes, and 0x14 reads, one of NUM_CTX context registers, indexed by the address register modulo NUM_CTX. Read timing is the same as in R3, and context access is allowed in any run state.
- R5: Opcode 0x02 sets the running state (bit 31 set, bit 30 clear). On every following clock edge while running, one instruction executes: the program counter and the execution count each rise by one, and the profile count rises by one.
- R6: Opcode 0x03 stops the core. No instruction executes on the edge that accepts the stop, and the counters and program counter then hold.
- R7: Opcode 0x01 while stopped executes exactly one instruction. The execution count and program counter rise by one, the profile count does not change, and the core stays stopped. A step issued while running is ignored.
- R8: Opcode 0x04 while stopped raises bit 29 for PIPE_CLR_CYCLES cycles, then sets the clean flag (bit 23). Any executed instruction clears the clean flag. The opcode is ignored while running.
- R9: A memory write opcode (0x11 or 0x13) while running leaves memory unchanged and sets the sticky error flag (bit 27). The flag clears when a command is accepted while the core is stopped.
- R10: Opcode 0x0C zeroes the profile count and leaves the execution count unchanged.
- R11: Control writes are ignored while busy or while the pipeline clear runs. Unknown opcodes change nothing.
- R12: The program counter (status bits 15:0) wraps from IMEM_DEPTH-1 to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational from host_addr |

## Verification
Memory traffic is tried with addresses inside the depth and with addresses one depth above, which shows whether the address is reduced modulo each memory's own size. Distinct data in each memory and in the context bank shows whether reads return from the right source. Run control is tried as a step, a timed free run, a run with blocked writes and a stray step, and a long run across the end of instruction memory. Comparing execution and profile counts separates steps from free-running cycles and exposes any instruction wrongly executed on the stop edge. Commands issued during a pipeline clear, and unknown opcodes, check that nothing moves.

// File: rtl/dbgp_pkg.sv
`timescale 1ns/1ps
package dbgp_pkg;
  localparam logic [7:0] OFS_ADDR = 8'h00;
  localparam logic [7:0] OFS_DATA = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h08;
  localparam logic [7:0] OFS_XCNT = 8'h0C;
  localparam logic [7:0] OFS_PCNT = 8'h28;

  localparam logic [7:0] CMD_STEP    = 8'h01;
  localparam logic [7:0] CMD_START   = 8'h02;
  localparam logic [7:0] CMD_STOP    = 8'h03;
  localparam logic [7:0] CMD_CLRPIPE = 8'h04;
  localparam logic [7:0] CMD_CLRPROF = 8'h0C;
  localparam logic [7:0] CMD_RD_IMEM = 8'h10;
  localparam logic [7:0] CMD_WR_IMEM = 8'h11;
  localparam logic [7:0] CMD_RD_DMEM = 8'h12;
  localparam logic [7:0] CMD_WR_DMEM = 8'h13;
  localparam logic [7:0] CMD_RD_CTX  = 8'h14;
  localparam logic [7:0] CMD_WR_CTX  = 8'h15;

  typedef enum logic [1:0] {SRC_IMEM, SRC_DMEM, SRC_CTX} rd_src_e;

  function automatic logic is_mem_write(input logic [7:0] c);
    return (c == CMD_WR_IMEM) || (c == CMD_WR_DMEM);
  endfunction

  function automatic logic [31:0] bump(input logic [31:0] v);
    return v + 32'd1;
  endfunction

  function automatic logic [31:0] pack_status(input logic run, input logic clr,
                                              input logic busy, input logic err,
                                              input logic clean, input logic [15:0] pc);
    logic [31:0] w;
    w        = '0;
    w[31]    = run;
    w[30]    = ~run;
    w[29]    = clr;
    w[28]    = busy;
    w[27]    = err;
    w[23]    = clean;
    w[15:0]  = pc;
    return w;
  endfunction
endpackage

// File: rtl/dbgp_mem.sv
`timescale 1ns/1ps
module dbgp_mem #(
  parameter int DEPTH = 4096,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [W-1:0]             wdata,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    if (re) rdata <= store[addr];
  end
endmodule

// File: rtl/dbgp_ctx.sv
`timescale 1ns/1ps
module dbgp_ctx #(
  parameter int NUM = 16,
  parameter int W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic                   re,
  input  logic [$clog2(NUM)-1:0] idx,
  input  logic [W-1:0]           wdata,
  output logic [W-1:0]           rdata
);
  localparam int XW = $clog2(NUM);
  logic [W-1:0] bank [NUM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) bank[i] <= '0;
      rdata <= '0;
    end else begin
      for (int i = 0; i < NUM; i++)
        if (we && idx == XW'(i)) bank[i] <= wdata;
      if (re) rdata <= bank[idx];
    end
  end
endmodule

// File: rtl/dbgp_core.sv
`timescale 1ns/1ps
module dbgp_core import dbgp_pkg::*; #(
  parameter int IMEM_DEPTH      = 4096,
  parameter int PIPE_CLR_CYCLES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          go_start,
  input  logic                          go_stop,
  input  logic                          go_step,
  input  logic                          go_clrpipe,
  input  logic                          go_clrprof,
  output logic                          running,
  output logic                          clearing,
  output logic                          clean,
  output logic [$clog2(IMEM_DEPTH)-1:0] pc,
  output logic [31:0]                   xcnt,
  output logic [31:0]                   pcnt,
  output logic                          exec_evt,
  output logic                          step_evt
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int CW  = $clog2(PIPE_CLR_CYCLES + 1);

  function automatic logic [IAW-1:0] pc_advance(input logic [IAW-1:0] p);
    return p + IAW'(1);
  endfunction

  logic [CW-1:0] clr_cnt;
  logic          free_evt;
  logic          clr_go;
  logic          clr_done;

  assign free_evt = running & ~go_stop;
  assign step_evt = go_step & ~running;
  assign exec_evt = free_evt | step_evt;
  assign clr_go   = go_clrpipe & ~running;
  assign clearing = (clr_cnt != '0);
  assign clr_done = (clr_cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      clr_cnt <= '0;
      clean   <= 1'b1;
      pc      <= '0;
      xcnt    <= '0;
      pcnt    <= '0;
    end else begin
      if (go_stop)                  running <= 1'b0;
      else if (go_start)            running <= 1'b1;

      if (clr_go)                   clr_cnt <= CW'(PIPE_CLR_CYCLES);
      else if (clearing)            clr_cnt <= clr_cnt - CW'(1);

      if (exec_evt)                 clean <= 1'b0;
      else if (clr_done)            clean <= 1'b1;

      if (exec_evt) begin
        pc   <= pc_advance(pc);
        xcnt <= bump(xcnt);
      end

      if (go_clrprof)               pcnt <= '0;
      else if (free_evt)            pcnt <= bump(pcnt);
    end
  end
endmodule

// File: rtl/dbg_exec_port.sv
`timescale 1ns/1ps
module dbg_exec_port import dbgp_pkg::*; #(
  parameter int IMEM_DEPTH      = 4096,
  parameter int DMEM_DEPTH      = 2048,
  parameter int NUM_CTX         = 16,
  parameter int PIPE_CLR_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam int CXW = $clog2(NUM_CTX);

  logic [31:0] acc_addr, acc_data;
  logic        busy, err;
  rd_src_e     rd_src;

  logic [7:0]  cmd;
  logic        ctrl_wr, accept;
  logic        running, clearing, clean, exec_evt, step_evt;
  logic [IAW-1:0] pc;
  logic [31:0] xcnt, pcnt;
  logic        imem_we, imem_re, dmem_we, dmem_re, ctx_we, ctx_re;
  logic        mem_wr_req, rd_req, prof_clr;
  logic [31:0] imem_q, dmem_q, ctx_q, rd_result;

  assign cmd        = host_wdata[7:0];
  assign ctrl_wr    = host_we && (host_addr == OFS_CTRL);
  assign accept     = ctrl_wr & ~busy & ~clearing;
  assign mem_wr_req = accept & is_mem_write(cmd);
  assign imem_we    = accept & (cmd == CMD_WR_IMEM) & ~running;
  assign dmem_we    = accept & (cmd == CMD_WR_DMEM) & ~running;
  assign ctx_we     = accept & (cmd == CMD_WR_CTX);
  assign imem_re    = accept & (cmd == CMD_RD_IMEM);
  assign dmem_re    = accept & (cmd == CMD_RD_DMEM);
  assign ctx_re     = accept & (cmd == CMD_RD_CTX);
  assign rd_req     = imem_re | dmem_re | ctx_re;
  assign prof_clr   = accept & (cmd == CMD_CLRPROF);

  dbgp_core #(
    .IMEM_DEPTH      (IMEM_DEPTH),
    .PIPE_CLR_CYCLES (PIPE_CLR_CYCLES)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_start   (accept & (cmd == CMD_START)),
    .go_stop    (accept & (cmd == CMD_STOP)),
    .go_step    (accept & (cmd == CMD_STEP)),
    .go_clrpipe (accept & (cmd == CMD_CLRPIPE)),
    .go_clrprof (prof_clr),
    .running    (running),
    .clearing   (clearing),
    .clean      (clean),
    .pc         (pc),
    .xcnt       (xcnt),
    .pcnt       (pcnt),
    .exec_evt   (exec_evt),
    .step_evt   (step_evt)
  );

  dbgp_mem #(.DEPTH(IMEM_DEPTH), .W(32)) u_imem (
    .clk (clk), .we (imem_we), .re (imem_re),
    .addr (acc_addr[IAW-1:0]), .wdata (acc_data), .rdata (imem_q)
  );

  dbgp_mem #(.DEPTH(DMEM_DEPTH), .W(32)) u_dmem (
    .clk (clk), .we (dmem_we), .re (dmem_re),
    .addr (acc_addr[DAW-1:0]), .wdata (acc_data), .rdata (dmem_q)
  );

  dbgp_ctx #(.NUM(NUM_CTX), .W(32)) u_ctx (
    .clk (clk), .rst_n (rst_n), .we (ctx_we), .re (ctx_re),
    .idx (acc_addr[CXW-1:0]), .wdata (acc_data), .rdata (ctx_q)
  );

  always_comb begin
    case (rd_src)
      SRC_IMEM: rd_result = imem_q;
      SRC_DMEM: rd_result = dmem_q;
      default:  rd_result = ctx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_addr <= '0;
      acc_data <= '0;
      busy     <= 1'b0;
      err      <= 1'b0;
      rd_src   <= SRC_IMEM;
    end else begin
      if (host_we && host_addr == OFS_ADDR) acc_addr <= host_wdata;

      if (busy)                                  acc_data <= rd_result;
      else if (host_we && host_addr == OFS_DATA) acc_data <= host_wdata;

      busy <= rd_req;
      if (imem_re)      rd_src <= SRC_IMEM;
      else if (dmem_re) rd_src <= SRC_DMEM;
      else if (ctx_re)  rd_src <= SRC_CTX;

      if (mem_wr_req && running)  err <= 1'b1;
      else if (accept && !running) err <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      OFS_ADDR: host_rdata = acc_addr;
      OFS_DATA: host_rdata = acc_data;
      OFS_CTRL: host_rdata = pack_status(running, clearing, busy, err, clean, 16'(pc));
      OFS_XCNT: host_rdata = xcnt;
      OFS_PCNT: host_rdata = pcnt;
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgp_chk.sv
`timescale 1ns/1ps
module dbgp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        running,
  input logic        busy,
  input logic        err,
  input logic        clearing,
  input logic        clean,
  input logic        exec_evt,
  input logic        step_evt,
  input logic        prof_clr,
  input logic        mem_wr_req,
  input logic        imem_we,
  input logic        dmem_we,
  input logic [31:0] xcnt,
  input logic [31:0] pcnt
);
  a_r3_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r9_no_mem_write_running: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we || dmem_we) |-> !running);

  a_r9_err_on_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && running) |=> err);

  a_r7_step_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> !running);

  a_r5_xcnt_advances: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt |=> xcnt == $past(xcnt) + 32'd1);

  a_r6_xcnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_evt |=> xcnt == $past(xcnt));

  a_r10_profile_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    prof_clr |=> pcnt == 32'd0);

  a_r8_exec_dirties_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt |=> !clean);

  a_r11_no_exec_while_clearing: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !exec_evt);
endmodule

bind dbg_exec_port dbgp_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .running    (running),
  .busy       (busy),
  .err        (err),
  .clearing   (clearing),
  .clean      (clean),
  .exec_evt   (exec_evt),
  .step_evt   (step_evt),
  .prof_clr   (prof_clr),
  .mem_wr_req (mem_wr_req),
  .imem_we    (imem_we),
  .dmem_we    (dmem_we),
  .xcnt       (xcnt),
  .pcnt       (pcnt)
);

// File: tb/test_dbg_exec_port.sv
`timescale 1ns/1ps
module test_dbg_exec_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  dbg_exec_port i_dbg_exec_port (
    .clk (clk), .rst_n (rst_n), .host_we (host_we),
    .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata)
  );

  localparam logic [7:0] A_ADDR = 8'h00, A_DATA = 8'h04, A_CTRL = 8'h08,
                         A_XCNT = 8'h0C, A_PCNT = 8'h28;

  function automatic logic [31:0] st(input bit run, input bit clr, input bit bsy,
                                     input bit er, input bit cln, input int pcv);
    return ({31'd0, run} << 31) | ({31'd0, !run} << 30) | ({31'd0, clr} << 29) |
           ({31'd0, bsy} << 28) | ({31'd0, er} << 27) | ({31'd0, cln} << 23) |
           (pcv & 32'hFFFF);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    host_addr = a;
    #0.1;
    check(tag, host_rdata, exp);
  endtask

  task automatic rdmem(input string tag, input int a, input logic [7:0] code,
                       input logic [31:0] exp);
    wr(A_DATA, 32'h0);
    wr(A_ADDR, a);
    wr(A_CTRL, {24'd0, code});
    host_addr = A_CTRL;
    #0.1;
    check({tag, " busy"}, (host_rdata >> 28) & 1, 1);
    @(negedge clk);
    rd_chk({tag, " data"}, A_DATA, exp);
    host_addr = A_CTRL;
    #0.1;
    check({tag, " busy drop"}, (host_rdata >> 28) & 1, 0);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", A_CTRL, 32'h4080_0000);
    rd_chk("R1 xcnt", A_XCNT, 0);
    rd_chk("R1 pcnt", A_PCNT, 0);
    rd_chk("R1 addr", A_ADDR, 0);
    rd_chk("R1 data", A_DATA, 0);
    rd_chk("R2 unmapped", 8'h10, 0);
  endtask

  task automatic t_regmap();
    wr(A_ADDR, 32'h0000_1005);
    wr(A_DATA, 32'hA5A5_0001);
    rd_chk("R2 addr", A_ADDR, 32'h0000_1005);
    rd_chk("R2 data", A_DATA, 32'hA5A5_0001);
  endtask

  task automatic t_access();
    wr(A_ADDR, 5);         wr(A_DATA, 32'h1111_AAAA); wr(A_CTRL, 8'h11);
    wr(A_DATA, 32'h2222_BBBB); wr(A_CTRL, 8'h13);
    wr(A_ADDR, 4096 + 7);  wr(A_DATA, 32'h3333_CCCC); wr(A_CTRL, 8'h11);
    wr(A_ADDR, 2048 + 9);  wr(A_DATA, 32'h4444_DDDD); wr(A_CTRL, 8'h13);
    wr(A_ADDR, 16 + 3);    wr(A_DATA, 32'h5555_EEEE); wr(A_CTRL, 8'h15);
    rdmem("R3 imem", 5, 8'h10, 32'h1111_AAAA);
    rdmem("R3 dmem", 5, 8'h12, 32'h2222_BBBB);
    rdmem("R3 imem wrap", 7, 8'h10, 32'h3333_CCCC);
    rdmem("R3 dmem wrap", 9, 8'h12, 32'h4444_DDDD);
    rdmem("R4 ctx", 3, 8'h14, 32'h5555_EEEE);
  endtask

  task automatic t_step();
    wr(A_CTRL, 8'h01);
    rd_chk("R7 step ctrl", A_CTRL, st(0, 0, 0, 0, 0, 1));
    rd_chk("R7 step xcnt", A_XCNT, 1);
    rd_chk("R7 step pcnt", A_PCNT, 0);
  endtask

  task automatic t_clear();
    wr(A_CTRL, 8'h04);
    rd_chk("R8 clearing", A_CTRL, st(0, 1, 0, 0, 0, 1));
    wr(A_CTRL, 8'h01);
    rd_chk("R11 step ignored while clearing", A_CTRL, st(0, 1, 0, 0, 0, 1));
    @(negedge clk);
    rd_chk("R8 still clearing", A_CTRL, st(0, 1, 0, 0, 0, 1));
    @(negedge clk);
    rd_chk("R8 clean after clear", A_CTRL, st(0, 0, 0, 0, 1, 1));
    wr(A_CTRL, 8'h7F);
    rd_chk("R11 unknown opcode", A_CTRL, st(0, 0, 0, 0, 1, 1));
    rd_chk("R11 unknown xcnt", A_XCNT, 1);
  endtask

  task automatic t_run();
    wr(A_CTRL, 8'h02);
    rd_chk("R5 running", A_CTRL, st(1, 0, 0, 0, 1, 1));
    repeat (10) @(negedge clk);
    wr(A_CTRL, 8'h03);
    rd_chk("R6 stopped", A_CTRL, st(0, 0, 0, 0, 0, 11));
    rd_chk("R5 xcnt", A_XCNT, 11);
    rd_chk("R5 pcnt", A_PCNT, 10);
    repeat (3) @(negedge clk);
    rd_chk("R6 hold xcnt", A_XCNT, 11);
  endtask

  task automatic t_err();
    wr(A_ADDR, 5);
    wr(A_DATA, 32'h9999_0000);
    wr(A_CTRL, 8'h02);
    wr(A_CTRL, 8'h11);
    host_addr = A_CTRL;
    #0.1;
    check("R9 err set", (host_rdata >> 27) & 1, 1);
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h03);
    rd_chk("R9 err sticky", A_CTRL, st(0, 0, 0, 1, 0, 13));
    rd_chk("R7 step ignored while running", A_XCNT, 13);
    rd_chk("R5 pcnt after err run", A_PCNT, 12);
    rdmem("R9 imem unchanged", 5, 8'h10, 32'h1111_AAAA);
    rd_chk("R9 err cleared", A_CTRL, st(0, 0, 0, 0, 0, 13));
  endtask

  task automatic t_prof();
    wr(A_CTRL, 8'h0C);
    rd_chk("R10 pcnt zero", A_PCNT, 0);
    rd_chk("R10 xcnt kept", A_XCNT, 13);
  endtask

  task automatic t_wrap();
    wr(A_CTRL, 8'h02);
    repeat (4086) @(negedge clk);
    wr(A_CTRL, 8'h03);
    rd_chk("R12 pc wrap", A_CTRL, st(0, 0, 0, 0, 0, 3));
    rd_chk("R12 xcnt", A_XCNT, 4099);
    rd_chk("R12 pcnt", A_PCNT, 4086);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_access();
    t_step();
    t_clear();
    t_run();
    t_err();
    t_prof();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule